// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserializes PCM audio arriving on a shared bit clock, a shared frame clock and three serial data lines. Each line normally carries one stereo pair, so three pairs arrive together. A packed time-division mode instead carries six channels on the first line alone. Every completed sample leaves the block as a 24-bit parallel word, together with a channel index and a one-cycle valid strobe. Downstream filter and converter logic takes these words.

The serial clocks are treated as data. They pass through a two-stage synchronizer into the fast system clock domain, and the block acts on each rising bit-clock edge it detects there. The format selector picks the framing: left-justified, I2S, right-justified, a pulse-framed DSP format, or packed six-slot TDM. The word-length selector picks 16, 20 or 24 bits. Serial data is MSB first and two's complement. Shorter words are placed at the top of the output word and the low bits are filled with zeros.

Top module: `serial_audio_rx`

## Requirements
- R1: Format code 0 (left-justified). The frame clock is low for the left channel and high for the right. The MSB is on the first rising bit-clock edge that sees the new frame-clock level. The next W-1 edges carry the rest of the word.
- R2: Format code 1 (I2S). Same framing as R1, but the MSB is one bit-clock edge later than in R1.
- R3: Format code 2 (right-justified). Each channel half-frame is 32 bit clocks long. The MSB falls on edge 32-W of the half-frame, counting from edge 0, so the word ends on edge 31.
- R4: Format code 3 (DSP). A frame-clock pulse that is high for one rising edge marks the left MSB. The right word follows directly after it, starting W edges later.
- R5: Format code 4 (TDM). The frame pulse marks the start of six 32-edge slots on data line 0. Each slot carries its word MSB-first starting at the slot's first edge. The channel index equals the slot number, 0 to 5.
- R6: Word-length code 0 selects W=16, code 1 selects W=20, and codes 2 and 3 select W=24. The output places bit W-1 of the word at bit 23 and fills the lower 24-W bits with zeros.
- R7: Serial bits outside a word window have no effect on any output word. In TDM mode, data lines 1 and 2 are ignored.
- R8: In stereo modes, the channel index is 2*line + side, where side is 0 for left and 1 for right. The three words completed on the same edge come out in ascending line order. The valid strobe is high for exactly one cycle per sample.
- R9: During reset and after it, the valid strobe is low. In stereo modes, no word is delivered until the frame clock has changed level once.
- R10: Format codes 5 to 7 behave exactly like code 0.
- R11: Each bit-clock phase must last at least 4 system clocks. Under that condition, one group of words is fully delivered before the next group completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel_i | input | 3 | Framing format code |
| wlen_sel_i | input | 2 | Word-length code |
| bclk_i | input | 1 | Serial bit clock |
| frame_i | input | 1 | Frame clock or frame pulse |
| sdata_i | input | 3 | Serial data lines, bit n is line n |
| smp_valid_o | output | 1 | One-cycle strobe per delivered sample |
| smp_chan_o | output | 3 | Channel index of the sample |
| smp_data_o | output | 24 | MSB-aligned two's complement sample |

## Verification
The bench fills every bit position outside a word window with random bits. A design that shifts in one bit too many or too few then returns corrupted, shifted words. Every framing is exercised at all three word lengths. In right-justified mode, a wrong start offset for a given length loses the sign bit. In DSP mode, a right window that starts late misplaces the right word. A short TDM slot stride sends samples to the wrong channel index. Extreme values at full and minimum range expose sign or zero-fill errors. A reset-then-frame sequence with no preceding frame-clock change checks that the left half before alignment is dropped. A design that skipped this would emit three extra samples, and the bench flags them as unexpected.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int WORD_MAX = 24;

  typedef enum logic [2:0] {
    FMT_LJ  = 3'd0,
    FMT_I2S = 3'd1,
    FMT_RJ  = 3'd2,
    FMT_DSP = 3'd3,
    FMT_TDM = 3'd4
  } fmt_e;

  // word-length code to bit count (R6)
  function automatic int wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return WORD_MAX;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             frame_i,
  input  logic [LANES-1:0] data_i,
  output logic             rise_o,
  output logic             frame_o,
  output logic [LANES-1:0] data_o
);

  localparam int SW = LANES + 2;

  logic [SW-1:0] st1_q, st2_q;
  logic          bclk_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q    <= '0;
      st2_q    <= '0;
      bclk_d_q <= 1'b0;
    end else begin
      st1_q    <= {bclk_i, frame_i, data_i};
      st2_q    <= st1_q;
      bclk_d_q <= st2_q[SW-1];
    end
  end

  assign rise_o  = st2_q[SW-1] & ~bclk_d_q;
  assign frame_o = st2_q[SW-2];
  assign data_o  = st2_q[LANES-1:0];

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int TDM_SLOTS = 6,
  parameter int CNT_W     = 8,
  parameter int CH_W      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise_i,
  input  logic            frame_i,
  input  logic [2:0]      fmt_i,
  input  logic [1:0]      wlen_i,
  output logic            win_o,
  output logic            last_o,
  output logic [CH_W-1:0] slot_o
);

  logic [CNT_W-1:0] pos_q, pos_d, pos_now;
  logic             frm_q, frm_d;
  logic [CNT_W-1:0] wl, start, kbit, slot;
  logic             pulse_mode, restart, in_win;
  fmt_e             fmt;

  always_comb begin
    fmt        = fmt_e'(fmt_i);
    wl         = CNT_W'(wlen_bits(wlen_i));
    pulse_mode = (fmt == FMT_DSP) || (fmt == FMT_TDM);
    restart    = pulse_mode ? frame_i : (frame_i != frm_q);
    if (restart)           pos_now = '0;
    else if (&pos_q)       pos_now = pos_q;
    else                   pos_now = pos_q + 1'b1;
    in_win = 1'b0;
    kbit   = '0;
    slot   = '0;
    start  = '0;
    case (fmt)
      FMT_DSP: begin
        if (pos_now < wl) begin
          in_win = 1'b1;
          kbit   = pos_now;
        end else if (pos_now < (wl << 1)) begin
          in_win = 1'b1;
          kbit   = pos_now - wl;
          slot   = CNT_W'(1);
        end
      end
      FMT_TDM: begin
        slot   = pos_now / CNT_W'(SLOT_BITS);
        kbit   = pos_now % CNT_W'(SLOT_BITS);
        in_win = (slot < CNT_W'(TDM_SLOTS)) && (kbit < wl);
      end
      default: begin
        if (fmt == FMT_I2S)     start = CNT_W'(1);
        else if (fmt == FMT_RJ) start = CNT_W'(SLOT_BITS) - wl;
        in_win = (pos_now >= start) && (pos_now < start + wl);
        kbit   = pos_now - start;
        slot   = {{(CNT_W-1){1'b0}}, frame_i};
      end
    endcase
    win_o  = rise_i && in_win;
    last_o = rise_i && in_win && (kbit == wl - 1'b1);
    slot_o = CH_W'(slot);
    pos_d  = rise_i ? pos_now : pos_q;
    frm_d  = rise_i ? frame_i : frm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '1;
      frm_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      frm_q <= frm_d;
    end
  end

endmodule

// File: rtl/aud_rx_lane.sv
module aud_rx_lane
  import aud_rx_pkg::*;
#(
  parameter int MAX_W = WORD_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic [1:0]       wlen_i,
  output logic [MAX_W-1:0] word_o
);

  localparam int AMT_W = $clog2(MAX_W + 1);

  logic [MAX_W-1:0] sh_q, sh_next;
  logic [AMT_W-1:0] pad;

  always_comb begin
    sh_next = {sh_q[MAX_W-2:0], bit_i};
    pad     = AMT_W'(MAX_W - wlen_bits(wlen_i));
    word_o  = sh_next << pad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (shift_i) sh_q <= sh_next;
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import aud_rx_pkg::*;
#(
  parameter int LANES     = 3,
  parameter int MAX_W     = WORD_MAX,
  parameter int SLOT_BITS = 32,
  parameter int TDM_SLOTS = 6,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fmt_sel_i,
  input  logic [1:0]       wlen_sel_i,
  input  logic             bclk_i,
  input  logic             frame_i,
  input  logic [LANES-1:0] sdata_i,
  output logic             smp_valid_o,
  output logic [2:0]       smp_chan_o,
  output logic [MAX_W-1:0] smp_data_o
);

  localparam int CH_W  = 3;
  localparam int PICK_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic             rise, frame_s, win, last;
  logic [LANES-1:0] data_s;
  logic [CH_W-1:0]  slot;
  logic [MAX_W-1:0] word [LANES];
  logic             is_tdm;

  aud_rx_sync #(.LANES(LANES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .frame_i(frame_i),
    .data_i(sdata_i), .rise_o(rise), .frame_o(frame_s), .data_o(data_s)
  );

  aud_rx_framer #(
    .SLOT_BITS(SLOT_BITS), .TDM_SLOTS(TDM_SLOTS), .CNT_W(CNT_W), .CH_W(CH_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .frame_i(frame_s),
    .fmt_i(fmt_sel_i), .wlen_i(wlen_sel_i),
    .win_o(win), .last_o(last), .slot_o(slot)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aud_rx_lane #(.MAX_W(MAX_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .shift_i(win), .bit_i(data_s[g]),
      .wlen_i(wlen_sel_i), .word_o(word[g])
    );
  end

  // group holding and output sequencing
  logic [MAX_W-1:0] hold_q [LANES];
  logic [LANES-1:0] pend_q, pend_d;
  logic             tdm_q, tdm_d;
  logic [CH_W-1:0]  slot_q, slot_d;
  logic [1:0]       len_q, len_d, olen_q;
  logic [PICK_W-1:0] pick;
  logic             val_d;
  logic [CH_W-1:0]  chan_d;
  logic [MAX_W-1:0] data_d;

  assign is_tdm = (fmt_e'(fmt_sel_i) == FMT_TDM);

  always_comb begin
    pick = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = PICK_W'(i);
    end
    val_d  = |pend_q;
    chan_d = tdm_q ? slot_q : CH_W'(32'(pick) * 2 + 32'(slot_q));
    data_d = hold_q[pick];
    pend_d = pend_q;
    if (val_d) pend_d[pick] = 1'b0;
    tdm_d  = tdm_q;
    slot_d = slot_q;
    len_d  = len_q;
    if (last) begin
      pend_d = is_tdm ? LANES'(1) : '1;
      tdm_d  = is_tdm;
      slot_d = slot;
      len_d  = wlen_sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      tdm_q       <= 1'b0;
      slot_q      <= '0;
      len_q       <= '0;
      olen_q      <= '0;
      smp_valid_o <= 1'b0;
      smp_chan_o  <= '0;
      smp_data_o  <= '0;
      for (int i = 0; i < LANES; i++) hold_q[i] <= '0;
    end else begin
      pend_q      <= pend_d;
      tdm_q       <= tdm_d;
      slot_q      <= slot_d;
      len_q       <= len_d;
      smp_valid_o <= val_d;
      if (val_d) begin
        smp_chan_o <= chan_d;
        smp_data_o <= data_d;
        olen_q     <= len_q;
      end
      if (last) begin
        for (int i = 0; i < LANES; i++) hold_q[i] <= word[i];
      end
    end
  end

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> (smp_chan_o < CH_W'(TDM_SLOTS))); // R8
  AST_PAD16_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && olen_q == 2'd0) |-> (smp_data_o[MAX_W-17:0] == '0)); // R6
  AST_PAD20_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && olen_q == 2'd1) |-> (smp_data_o[MAX_W-21:0] == '0)); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (pend_q == '0)); // R11
  AST_VALID_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> $past(pend_q != '0)); // R8

endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic [1:0]  wlen_sel = 2'd2;
  logic        bclk = 1'b0;
  logic        frame = 1'b0;
  logic [2:0]  sdata = 3'd0;
  logic        smp_valid;
  logic [2:0]  smp_chan;
  logic [23:0] smp_data;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .fmt_sel_i(fmt_sel), .wlen_sel_i(wlen_sel),
    .bclk_i(bclk), .frame_i(frame), .sdata_i(sdata),
    .smp_valid_o(smp_valid), .smp_chan_o(smp_chan), .smp_data_o(smp_data)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int wr = 0;
  int rd = 0;
  int          exp_ch  [0:2047];
  logic [23:0] exp_d   [0:2047];
  int          exp_req [0:2047];
  logic [23:0] smp [0:5];

  function automatic int wbits(input int wc);
    return (wc == 0) ? 16 : (wc == 1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] aligned(input logic [23:0] s, input int w);
    logic [23:0] m;
    m = (24'h1 << w) - 24'h1;
    if (w == 24) m = 24'hFFFFFF;
    return (s & m) << (24 - w);
  endfunction

  function automatic int req_of(input int f);
    case (f)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      default: return 10;
    endcase
  endfunction

  task automatic push(input int ch, input logic [23:0] d, input int rq);
    exp_ch[wr] = ch; exp_d[wr] = d; exp_req[wr] = rq; wr++;
  endtask

  task automatic tick(input logic fr, input logic [2:0] d);
    @(negedge clk);
    bclk = 1'b0; frame = fr; sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic junk();
    return logic'($urandom % 2);
  endfunction

  // stereo framings R1 R2 R3 R10; pre=0 skips the aligning edge (R9)
  task automatic send_std(input int f, input int wc, input bit pre, input bit skip_left);
    int w, st, k;
    logic [2:0] d;
    w  = wbits(wc);
    st = (f == 1) ? 1 : (f == 2) ? 32 - w : 0;
    fmt_sel = 3'(f); wlen_sel = 2'(wc);
    for (int h = 0; h < 2; h++)
      if (!(skip_left && h == 0))
        for (int l = 0; l < 3; l++) push(2 * l + h, aligned(smp[2 * l + h], w), req_of(f));
    if (pre) tick(1'b1, {junk(), junk(), junk()});
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 32; p++) begin
        k = p - st;
        for (int l = 0; l < 3; l++)
          d[l] = (k >= 0 && k < w) ? smp[2 * l + h][w - 1 - k] : junk(); // R7 junk
        tick(logic'(h), d);
      end
  endtask

  task automatic send_dsp(input int wc);
    int w;
    logic [2:0] d;
    w = wbits(wc);
    fmt_sel = 3'd3; wlen_sel = 2'(wc);
    for (int h = 0; h < 2; h++)
      for (int l = 0; l < 3; l++) push(2 * l + h, aligned(smp[2 * l + h], w), 4);
    for (int p = 0; p < 64; p++) begin
      for (int l = 0; l < 3; l++)
        d[l] = (p < w) ? smp[2 * l][w - 1 - p] :
               (p < 2 * w) ? smp[2 * l + 1][2 * w - 1 - p] : junk();
      tick(p == 0, d);
    end
  endtask

  task automatic send_tdm(input int wc);
    int w, s, k;
    logic [2:0] d;
    w = wbits(wc);
    fmt_sel = 3'd4; wlen_sel = 2'(wc);
    for (int c = 0; c < 6; c++) push(c, aligned(smp[c], w), 5);
    for (int p = 0; p < 192; p++) begin
      s = p / 32; k = p % 32;
      d = {junk(), junk(), junk()}; // lines 1,2 ignored (R7)
      d[0] = (k < w) ? smp[s][w - 1 - k] : junk();
      tick(p == 0, d);
    end
  endtask

  task automatic rand_smp();
    for (int c = 0; c < 6; c++) smp[c] = 24'($urandom);
  endtask

  // scoreboard: R6 alignment, R8 channel order and one sample per strobe
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      checks++;
      if (rd >= wr) begin
        errors++;
        $display("FAIL R8 unexpected sample chan=%0d data=%h expected none", smp_chan, smp_data);
      end else begin
        if (smp_chan !== 3'(exp_ch[rd]) || smp_data !== exp_d[rd]) begin
          errors++;
          $display("FAIL R%0d/R6/R8 chan=%0d data=%h expected chan=%0d data=%h",
                   exp_req[rd], smp_chan, smp_data, exp_ch[rd], exp_d[rd]);
        end
        rd++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=%0d expected=%0d", rd, wr);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    checks++; // R9 reset state
    if (smp_valid !== 1'b0) begin
      errors++; $display("FAIL R9 valid during reset got=%b expected=0", smp_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (smp_valid !== 1'b0) begin
      errors++; $display("FAIL R9 valid after reset got=%b expected=0", smp_valid);
    end
    // R9: left half before any frame-clock change is dropped
    rand_smp();
    send_std(0, 2, 1'b0, 1'b1);
    // directed extremes, R6 sign and zero fill, R10 codes
    smp[0] = 24'h800000; smp[1] = 24'h7FFFFF; smp[2] = 24'h000001;
    smp[3] = 24'hFFFFFF; smp[4] = 24'h000000; smp[5] = 24'h400000;
    send_std(0, 3, 1'b1, 1'b0);  // R6 code 3 acts as 24
    smp[0] = 24'h008000; smp[1] = 24'h007FFF; smp[2] = 24'h00FFFF;
    send_std(2, 0, 1'b1, 1'b0);  // R3 16-bit right-justified
    smp[0] = 24'h080000; smp[1] = 24'h07FFFF;
    send_std(1, 1, 1'b1, 1'b0);  // R2 20-bit
    send_dsp(0);                 // R4 16-bit
    send_tdm(1);                 // R5 20-bit
    rand_smp(); send_std(6, 0, 1'b1, 1'b0); // R10
    // constrained random mix, R1..R5 at all word lengths
    for (int n = 0; n < 36; n++) begin
      int f, wc;
      f  = int'($urandom % 6);
      wc = int'($urandom % 3);
      rand_smp();
      if (f == 3) send_dsp(wc);
      else if (f == 4) send_tdm(wc);
      else if (f == 5) send_std(7, wc, 1'b1, 1'b0);
      else send_std(f, wc, 1'b1, 1'b0);
    end
    repeat (40) @(negedge clk);
    checks++; // R8 all expected samples delivered
    if (rd != wr) begin
      errors++; $display("FAIL R8 delivered count got=%0d expected=%0d", rd, wr);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule